// File: doc/BRIEF.md
# I3C Target Dynamic Address Engine

This block is the byte-level front end of an I3C target that handles the common command codes every target must support. When the bus reports a START with an address, the block decides whether this target answers, and reports that decision as an acknowledge one cycle later. When a START carries the broadcast flag, the first byte written after it is taken as a common command code. The block then runs that command. It can assign a dynamic address through the arbitration sequence, reset the dynamic address, copy the static address into the dynamic address, set a new dynamic address, and enter or leave test mode. It also returns its 48-bit provisioned ID, its bus characteristics byte and its device characteristics byte on read requests.

The surrounding controller logic decodes the wire, delivers START, STOP, written bytes and read requests as single-cycle pulses, and drives a level that marks an address-arbitration sequence in progress. The provisioned ID, the two characteristic bytes and the static address are configuration inputs. Device-specific commands and private transfers are not handled here. A written byte that is not part of a command is ignored.

Top module: `i3c_daa_engine`

## Requirements
- R1: After reset the dynamic address is 0, test mode is off and no command is active, so a read request returns 8'hFF.
- R2: Outside arbitration a non-broadcast START is acknowledged when its address equals the effective address: the dynamic address when nonzero, otherwise the static address. Once a dynamic address is assigned, the static address no longer matches. `ack` is valid with `ack_vld` in the cycle after `start_vld`.
- R3: Outside arbitration a broadcast START is always acknowledged. It ends any active command and clears the byte offset.
- R4: While `bus_daa` is high, a non-broadcast START is refused. A broadcast START is acknowledged only when the dynamic address is 0.
- R5: The command code is captured from the first write after an acknowledged broadcast START while no command is active. The codes are: arbitration 8'h07, address reset 8'h06, test mode 8'h0B, static copy to all 8'h29, static copy direct 8'h87, new address 8'h88, ID read 8'h8D, BCR read 8'h8E, DCR read 8'h8F. A write after a non-broadcast START with no command active has no effect.
- R6: During arbitration, reads return the 6 ID bytes least significant first, then BCR, then DCR, and 8'hFF after that. The byte offset is kept across repeated broadcast STARTs while `bus_daa` is high.
- R7: After the 8 arbitration bytes have been read, the next write sets the dynamic address to its low 7 bits and ends the command.
- R8: Both static copy codes set the dynamic address to the static address on the code byte. The address reset code sets it to 0.
- R9: After the new-address code, the next written byte's low 7 bits become the dynamic address.
- R10: After the test-mode code, a nonzero byte enters test mode and a zero byte leaves it. In test mode the arbitration ID is 48'h0000554D4551.
- R11: The ID read returns the 6 configured ID bytes least significant first, then 8'hFF. The BCR read and DCR read each return their byte.
- R12: STOP ends the command, clears the byte offset and deselects the target. A read with no active command, or while deselected, returns 8'hFF.
- R13: `rd_vld` pulses, with `rd_data`, in the cycle after `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_vld | input | 1 | START or repeated START with address |
| start_addr | input | 7 | Address sent with the START |
| start_bcast | input | 1 | START carries the broadcast address |
| bus_daa | input | 1 | Address arbitration in progress on the bus |
| stop | input | 1 | STOP seen on the bus |
| wr_vld | input | 1 | Written byte strobe |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Read byte request |
| cfg_id | input | 48 | Provisioned ID |
| cfg_bcr | input | 8 | Bus characteristics byte |
| cfg_dcr | input | 8 | Device characteristics byte |
| cfg_static | input | 7 | Static address |
| ack_vld | output | 1 | Address decision valid |
| ack | output | 1 | Address acknowledged |
| rd_vld | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| dyn_addr | output | 7 | Current dynamic address |

## Verification
A vector table sweeps the combinations of broadcast flag, arbitration level and address against the static address. This separates the matching rule used outside arbitration from the rule used during it. Directed sequences then run complete and interrupted arbitrations. They split reads across repeated STARTs, to show that the offset survives a repeated START, and add a STOP mid-stream, to show that STOP resets the offset. Further sequences check the address-setting commands against each other and against a private write of an address-reset code. Test mode is checked by the identity of the first streamed byte, and ID, BCR and DCR reads show which configuration field reaches `rd_data`.

// File: rtl/i3cd_pkg.sv
package i3cd_pkg;
  localparam logic [7:0] CCC_RSTDAA   = 8'h06;
  localparam logic [7:0] CCC_ENTDAA   = 8'h07;
  localparam logic [7:0] CCC_ENTTM    = 8'h0B;
  localparam logic [7:0] CCC_SETAASA  = 8'h29;
  localparam logic [7:0] CCC_SETDASA  = 8'h87;
  localparam logic [7:0] CCC_SETNEWDA = 8'h88;
  localparam logic [7:0] CCC_GETPID   = 8'h8D;
  localparam logic [7:0] CCC_GETBCR   = 8'h8E;
  localparam logic [7:0] CCC_GETDCR   = 8'h8F;
  localparam logic [47:0] TEST_ID     = 48'h0000554D4551;
endpackage

// File: rtl/i3cd_addr_match.sv
module i3cd_addr_match #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] dyn_addr,
  input  logic [ADDR_W-1:0] static_addr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_bcast,
  input  logic              bus_daa,
  output logic              hit
);
  logic [ADDR_W-1:0] eff_addr;
  logic              dyn_zero;

  always_comb begin
    dyn_zero = (dyn_addr == '0);
    eff_addr = dyn_zero ? static_addr : dyn_addr;
    if (bus_daa) begin
      hit = start_bcast && dyn_zero;
    end else begin
      hit = start_bcast || (start_addr == eff_addr);
    end
  end
endmodule

// File: rtl/i3cd_ccc_ctrl.sv
module i3cd_ccc_ctrl
  import i3cd_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int ID_BYTES = 6,
  parameter int OFS_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_vld,
  input  logic              start_bcast,
  input  logic              bus_daa,
  input  logic              hit,
  input  logic              stop,
  input  logic              wr_vld,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] static_addr,
  output logic              sel_q,
  output logic              act_q,
  output logic [7:0]        code_q,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [ADDR_W-1:0] dyn_q,
  output logic              tm_q,
  output logic              ack_vld_q,
  output logic              ack_q
);
  localparam logic [OFS_W-1:0] DAA_LEN = OFS_W'(ID_BYTES + 2);
  localparam logic [OFS_W-1:0] ID_LEN  = OFS_W'(ID_BYTES);

  logic              sel_n, act_n, tm_n, bfr_n, bfr_q, ack_vld_n, ack_n;
  logic [7:0]        code_n;
  logic [OFS_W-1:0]  ofs_n;
  logic [ADDR_W-1:0] dyn_n;
  logic              upd_en;

  assign upd_en = stop | start_vld | wr_vld | rd_req | ack_vld_q;

  always_comb begin
    sel_n     = sel_q;
    bfr_n     = bfr_q;
    act_n     = act_q;
    code_n    = code_q;
    ofs_n     = ofs_q;
    dyn_n     = dyn_q;
    tm_n      = tm_q;
    ack_vld_n = 1'b0;
    ack_n     = 1'b0;
    if (stop) begin
      sel_n  = 1'b0;
      bfr_n  = 1'b0;
      act_n  = 1'b0;
      code_n = '0;
      ofs_n  = '0;
    end else if (start_vld) begin
      ack_vld_n = 1'b1;
      ack_n     = hit;
      sel_n     = hit;
      bfr_n     = start_bcast;
      if (start_bcast && !bus_daa) begin
        act_n  = 1'b0;
        code_n = '0;
        ofs_n  = '0;
      end
    end else if (wr_vld && sel_q) begin
      if (!act_q) begin
        if (bfr_q) begin
          act_n  = 1'b1;
          code_n = wr_data;
          ofs_n  = '0;
          case (wr_data)
            CCC_SETAASA, CCC_SETDASA: dyn_n = static_addr;
            CCC_RSTDAA:               dyn_n = '0;
            default: ;
          endcase
        end
      end else begin
        case (code_q)
          CCC_ENTDAA: begin
            if (ofs_q == DAA_LEN) begin
              dyn_n  = wr_data[ADDR_W-1:0];
              act_n  = 1'b0;
              code_n = '0;
              ofs_n  = '0;
            end
          end
          CCC_SETNEWDA: dyn_n = wr_data[ADDR_W-1:0];
          CCC_ENTTM:    tm_n  = |wr_data;
          default: ;
        endcase
      end
    end else if (rd_req && sel_q && act_q) begin
      if ((code_q == CCC_ENTDAA && ofs_q < DAA_LEN) ||
          (code_q == CCC_GETPID && ofs_q < ID_LEN)) begin
        ofs_n = ofs_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      bfr_q     <= 1'b0;
      act_q     <= 1'b0;
      code_q    <= '0;
      ofs_q     <= '0;
      dyn_q     <= '0;
      tm_q      <= 1'b0;
      ack_vld_q <= 1'b0;
      ack_q     <= 1'b0;
    end else if (upd_en) begin
      sel_q     <= sel_n;
      bfr_q     <= bfr_n;
      act_q     <= act_n;
      code_q    <= code_n;
      ofs_q     <= ofs_n;
      dyn_q     <= dyn_n;
      tm_q      <= tm_n;
      ack_vld_q <= ack_vld_n;
      ack_q     <= ack_n;
    end
  end
endmodule

// File: rtl/i3cd_rd_mux.sv
module i3cd_rd_mux
  import i3cd_pkg::*;
#(
  parameter int ID_BYTES = 6,
  parameter int OFS_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_req,
  input  logic                  sel,
  input  logic                  act,
  input  logic [7:0]            code,
  input  logic [OFS_W-1:0]      ofs,
  input  logic                  tm,
  input  logic [8*ID_BYTES-1:0] id_cfg,
  input  logic [7:0]            bcr,
  input  logic [7:0]            dcr,
  output logic                  rd_vld_q,
  output logic [7:0]            rd_data_q
);
  localparam int ID_W = 8 * ID_BYTES;

  logic [ID_W-1:0] daa_id;
  logic [7:0]      daa_byte [ID_BYTES];
  logic [7:0]      pid_byte [ID_BYTES];
  logic [7:0]      daa_pick, pid_pick, byte_n;
  logic            in_id;

  assign daa_id = tm ? ID_W'(TEST_ID) : id_cfg;

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_bytes
    assign daa_byte[g] = daa_id[8*g +: 8];
    assign pid_byte[g] = id_cfg[8*g +: 8];
  end

  always_comb begin
    daa_pick = 8'hFF;
    pid_pick = 8'hFF;
    in_id    = (ofs < OFS_W'(ID_BYTES));
    for (int i = 0; i < ID_BYTES; i++) begin
      if (ofs == OFS_W'(i)) begin
        daa_pick = daa_byte[i];
        pid_pick = pid_byte[i];
      end
    end
    byte_n = 8'hFF;
    if (sel && act) begin
      case (code)
        CCC_ENTDAA: begin
          if (in_id)                              byte_n = daa_pick;
          else if (ofs == OFS_W'(ID_BYTES))       byte_n = bcr;
          else if (ofs == OFS_W'(ID_BYTES + 1))   byte_n = dcr;
        end
        CCC_GETPID: if (in_id) byte_n = pid_pick;
        CCC_GETBCR: byte_n = bcr;
        CCC_GETDCR: byte_n = dcr;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= 8'hFF;
    end else begin
      rd_vld_q <= rd_req;
      if (rd_req) begin
        rd_data_q <= byte_n;
      end
    end
  end
endmodule

// File: rtl/i3c_daa_engine.sv
module i3c_daa_engine #(
  parameter int ADDR_W   = 7,
  parameter int ID_BYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_vld,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic                  start_bcast,
  input  logic                  bus_daa,
  input  logic                  stop,
  input  logic                  wr_vld,
  input  logic [7:0]            wr_data,
  input  logic                  rd_req,
  input  logic [8*ID_BYTES-1:0] cfg_id,
  input  logic [7:0]            cfg_bcr,
  input  logic [7:0]            cfg_dcr,
  input  logic [ADDR_W-1:0]     cfg_static,
  output logic                  ack_vld,
  output logic                  ack,
  output logic                  rd_vld,
  output logic [7:0]            rd_data,
  output logic [ADDR_W-1:0]     dyn_addr
);
  localparam int OFS_W = $clog2(ID_BYTES + 3);

  logic              hit, sel, act, tm;
  logic [7:0]        code;
  logic [OFS_W-1:0]  ofs;
  logic [ADDR_W-1:0] dyn;

  assign dyn_addr = dyn;

  i3cd_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .dyn_addr(dyn), .static_addr(cfg_static), .start_addr(start_addr),
    .start_bcast(start_bcast), .bus_daa(bus_daa), .hit(hit)
  );

  i3cd_ccc_ctrl #(.ADDR_W(ADDR_W), .ID_BYTES(ID_BYTES), .OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_bcast(start_bcast),
    .bus_daa(bus_daa), .hit(hit), .stop(stop), .wr_vld(wr_vld),
    .wr_data(wr_data), .rd_req(rd_req), .static_addr(cfg_static),
    .sel_q(sel), .act_q(act), .code_q(code), .ofs_q(ofs), .dyn_q(dyn),
    .tm_q(tm), .ack_vld_q(ack_vld), .ack_q(ack)
  );

  i3cd_rd_mux #(.ID_BYTES(ID_BYTES), .OFS_W(OFS_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .sel(sel), .act(act),
    .code(code), .ofs(ofs), .tm(tm), .id_cfg(cfg_id), .bcr(cfg_bcr),
    .dcr(cfg_dcr), .rd_vld_q(rd_vld), .rd_data_q(rd_data)
  );
endmodule

// File: rtl/i3cd_chk.sv
module i3cd_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_vld,
  input logic [ADDR_W-1:0] start_addr,
  input logic              start_bcast,
  input logic              bus_daa,
  input logic              stop,
  input logic              wr_vld,
  input logic              rd_req,
  input logic [ADDR_W-1:0] cfg_static,
  input logic              ack_vld,
  input logic              ack,
  input logic              rd_vld,
  input logic [ADDR_W-1:0] dyn_addr
);
  logic [ADDR_W-1:0] eff;
  assign eff = (dyn_addr != '0) ? dyn_addr : cfg_static;

  // R2
  mismatch_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_vld && !stop && !bus_daa && !start_bcast && start_addr != eff |=> ack_vld && !ack);

  // R2
  match_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_vld && !stop && !bus_daa && !start_bcast && start_addr == eff |=> ack_vld && ack);

  // R3
  bcast_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_vld && !stop && !bus_daa && start_bcast |=> ack_vld && ack);

  // R4
  daa_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_vld && !stop && bus_daa && (!start_bcast || dyn_addr != '0) |=> !ack);

  // R2
  ack_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_vld |=> !ack_vld);

  // R13
  rd_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_vld);

  // R13
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_vld);

  // R5
  dyn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld |=> $stable(dyn_addr));
endmodule

bind i3c_daa_engine i3cd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_addr(start_addr),
  .start_bcast(start_bcast), .bus_daa(bus_daa), .stop(stop), .wr_vld(wr_vld),
  .rd_req(rd_req), .cfg_static(cfg_static), .ack_vld(ack_vld), .ack(ack),
  .rd_vld(rd_vld), .dyn_addr(dyn_addr)
);

// File: tb/test_i3c_daa_engine.sv
module test_i3c_daa_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_vld, start_bcast, bus_daa, stop, wr_vld, rd_req;
  logic [6:0]  start_addr;
  logic [7:0]  wr_data;
  logic [47:0] cfg_id = 48'hA1B2C3D4E5F6;
  logic [7:0]  cfg_bcr = 8'h66;
  logic [7:0]  cfg_dcr = 8'h42;
  logic [6:0]  cfg_static = 7'h2A;
  logic        ack_vld, ack, rd_vld;
  logic [7:0]  rd_data;
  logic [6:0]  dyn_addr;
  int          n_chk = 0;
  int          n_err = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  i3c_daa_engine i_i3c_daa_engine (
    .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_addr(start_addr),
    .start_bcast(start_bcast), .bus_daa(bus_daa), .stop(stop),
    .wr_vld(wr_vld), .wr_data(wr_data), .rd_req(rd_req), .cfg_id(cfg_id),
    .cfg_bcr(cfg_bcr), .cfg_dcr(cfg_dcr), .cfg_static(cfg_static),
    .ack_vld(ack_vld), .ack(ack), .rd_vld(rd_vld), .rd_data(rd_data),
    .dyn_addr(dyn_addr)
  );

  // {bcast, daa, addr[6:0], expected ack}, dynamic address 0, static 0x2A
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 7'h2A, 1'b1},
    {1'b0, 1'b0, 7'h2B, 1'b0},
    {1'b1, 1'b0, 7'h11, 1'b1},
    {1'b0, 1'b1, 7'h2A, 1'b0},
    {1'b1, 1'b1, 7'h7E, 1'b1},
    {1'b0, 1'b0, 7'h00, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic b, input logic [6:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    start_vld = 1'b1; start_bcast = b; start_addr = a;
    @(negedge clk);
    start_vld = 1'b0;
    check(req, {ack_vld, ack}, {1'b1, exp[0]});
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_vld = 1'b1; wr_data = d;
    @(negedge clk);
    wr_vld = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check(req, {rd_vld, rd_data}, {1'b1, exp});
  endtask

  task automatic do_stop();
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic bcast_ccc(input logic [7:0] code);
    do_start(1'b1, 7'h7E, 1, "R3");
    do_write(code);
  endtask

  task automatic run_daa_to_assign(input logic [7:0] newa);
    do_stop();
    bcast_ccc(8'h07);
    bus_daa = 1'b1;
    do_start(1'b1, 7'h7E, 1, "R4");
    for (int i = 0; i < 8; i++) do_read(8'h00, "R6_skip");
  endtask

  initial begin
    rst_n = 1'b0; start_vld = 0; start_bcast = 0; bus_daa = 0; stop = 0;
    wr_vld = 0; rd_req = 0; start_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", dyn_addr, 7'h00);
    do_read(8'hFF, "R1");

    for (int i = 0; i < 6; i++) begin
      bus_daa = VEC[i][8];
      do_start(VEC[i][9], VEC[i][7:1], {31'd0, VEC[i][0]}, "R2_R4_vec");
      do_stop();
      bus_daa = 1'b0;
    end

    // arbitration with split reads across a repeated START
    bcast_ccc(8'h07);
    bus_daa = 1'b1;
    do_start(1'b1, 7'h7E, 1, "R4");
    do_read(8'hF6, "R6"); do_read(8'hE5, "R6"); do_read(8'hD4, "R6");
    do_start(1'b1, 7'h7E, 1, "R6");
    do_read(8'hC3, "R6"); do_read(8'hB2, "R6"); do_read(8'hA1, "R6");
    do_read(8'h66, "R6"); do_read(8'h42, "R6"); do_read(8'hFF, "R6");
    do_write(8'h35);
    check("R7", dyn_addr, 7'h35);
    do_start(1'b1, 7'h7E, 0, "R4");
    do_start(1'b0, 7'h35, 0, "R4");
    do_stop();
    bus_daa = 1'b0;
    do_start(1'b0, 7'h2A, 0, "R2");
    do_start(1'b0, 7'h35, 1, "R2");

    // BCR / DCR / ID reads
    do_stop(); bcast_ccc(8'h8E); do_start(1'b0, 7'h35, 1, "R2");
    do_read(8'h66, "R11");
    do_stop(); bcast_ccc(8'h8F); do_start(1'b0, 7'h35, 1, "R2");
    do_read(8'h42, "R11");
    do_stop(); bcast_ccc(8'h8D); do_start(1'b0, 7'h35, 1, "R2");
    do_read(8'hF6, "R11"); do_read(8'hE5, "R11"); do_read(8'hD4, "R11");
    do_read(8'hC3, "R11"); do_read(8'hB2, "R11"); do_read(8'hA1, "R11");
    do_read(8'hFF, "R11");
    do_stop();
    do_read(8'hFF, "R12");

    // test mode then arbitration
    bcast_ccc(8'h0B); do_write(8'h01); do_stop();
    bcast_ccc(8'h06); do_stop();
    check("R8", dyn_addr, 7'h00);
    bcast_ccc(8'h07);
    bus_daa = 1'b1;
    do_start(1'b1, 7'h7E, 1, "R4");
    do_read(8'h51, "R10"); do_read(8'h45, "R10"); do_read(8'h4D, "R10");
    do_read(8'h55, "R10"); do_read(8'h00, "R10"); do_read(8'h00, "R10");
    do_read(8'h66, "R10"); do_read(8'h42, "R10");
    do_write(8'h12);
    check("R7", dyn_addr, 7'h12);
    do_stop(); bus_daa = 1'b0;
    bcast_ccc(8'h0B); do_write(8'h00); do_stop();
    bcast_ccc(8'h06); do_stop();

    // STOP mid-arbitration restarts the stream
    bcast_ccc(8'h07);
    bus_daa = 1'b1;
    do_start(1'b1, 7'h7E, 1, "R4");
    do_read(8'hF6, "R10_exit");
    do_read(8'hE5, "R6");
    do_stop();
    do_read(8'hFF, "R12");
    bus_daa = 1'b0;
    bcast_ccc(8'h07);
    bus_daa = 1'b1;
    do_start(1'b1, 7'h7E, 1, "R4");
    do_read(8'hF6, "R12");
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    end
    do_write(8'h20);
    check("R7", dyn_addr, 7'h20);
    do_stop(); bus_daa = 1'b0;

    // new address command
    bcast_ccc(8'h88);
    do_start(1'b0, 7'h20, 1, "R2");
    do_write(8'h44);
    do_stop();
    check("R9", dyn_addr, 7'h44);

    // private write of a reset code has no effect
    do_start(1'b0, 7'h44, 1, "R2");
    do_write(8'h06);
    do_stop();
    check("R5", dyn_addr, 7'h44);

    // static copies and reset
    bcast_ccc(8'h29); do_stop();
    check("R8", dyn_addr, 7'h2A);
    bcast_ccc(8'h06); do_stop();
    check("R8", dyn_addr, 7'h00);
    bcast_ccc(8'h87); do_stop();
    check("R8", dyn_addr, 7'h2A);

    // unknown code reads back 0xFF
    bcast_ccc(8'h55);
    do_read(8'hFF, "R12");
    do_stop();

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule